// File: doc/BRIEF.md
# ADC Sample Conditioning Pipeline

This block turns the raw signed conversion results of one converter channel into formatted 24-bit output words. Each accepted sample, marked by a one-cycle strobe, passes through four steps in a fixed order. First comes optional block averaging over 2, 4, 8 or 16 consecutive samples. Next the result is coded as two's complement or offset binary. Then an optional XOR scrambling step runs, keyed either by the result's own least significant bit or by a pseudo-random bit. Last, a six-bit channel tag is appended.

All configuration inputs are static register values held by the surrounding logic. A chip serving two channels places two instances side by side, each with its own configuration and tag. Each output word is registered and appears together with a one-cycle valid strobe on the clock edge after the sample that completes it.

Top module: `adc_cond_pipe`

## Requirements
- R1: With averaging off, every input strobe yields exactly one output strobe on the next clock edge. With coding set to two's complement and scrambling off, bits 23..6 of the word equal the 18-bit sample.
- R2: With averaging on, depth code d (0..3) sets a block of N = 2^(d+1) strobes. The output strobe rises only on the edge after the N-th strobe of a block, so there is exactly one output per N inputs.
- R3: The averaged result is the signed sum of the block shifted right arithmetically by d+1, which rounds toward minus infinity.
- R4: Coding input 1 gives two's complement. Coding input 0 gives offset binary: the result MSB (word bit 23) is inverted.
- R5: In LSB scrambling mode (scramble enable 1, source select 0), word bit 6 carries the coded result LSB unchanged, and word bits 23..7 carry coded bits 17..1, each XORed with that LSB.
- R6: In random scrambling mode (scramble enable 1, source select 1), bits 23..6 carry the coded result XORed bitwise with a random bit p. Bit 5 carries p, and bits 4..0 carry tag bits 4..0.
- R7: The random bit comes from a 23-bit shift register seeded to all ones at reset. p is its bit 22. On every output word the register shifts left by one, and bit 22 XOR bit 17 enters at bit 0 (x^23 + x^18 + 1).
- R8: Outside random scrambling mode, word bits 5..0 equal the 6-bit tag input.
- R9: During reset the output strobe is low and the word is zero. Any partial average is cleared.
- R10: Cycles without an input strobe produce no output strobe and leave a partial average untouched.
- R11: Turning averaging off for any cycle discards a partial block. The next block starts counting from its first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 18 | Two's-complement conversion result |
| avg_en_i | input | 1 | Averaging enable |
| avg_depth_i | input | 2 | Averaging depth code, N = 2^(code+1) |
| fmt_twos_i | input | 1 | 1: two's complement, 0: offset binary |
| xor_en_i | input | 1 | Scrambling enable |
| xor_prbs_i | input | 1 | Scrambling source: 0 result LSB, 1 random bit |
| tag_i | input | 6 | Channel tag bits appended to the word |
| out_vld_o | output | 1 | Output word strobe |
| out_word_o | output | 24 | Formatted output word |

## Verification
Pass-through words use positive, negative, full-scale negative and minus-one samples under both codings. This separates the MSB inversion from plain sign handling, and a tag differing from the data exposes misplaced fields. LSB scrambling runs with odd and even samples, so a missing XOR or a scrambled LSB shows as a wrong word. Averaging runs at depths 2, 4 and 16 with mixed-sign blocks whose sums are not multiples of N, which tells floor rounding apart from truncation. Idle gaps and an enable drop inside a block show whether the sample count is kept or discarded correctly. Random mode runs after a fresh reset, so the first words pin down both the seed and the feedback taps.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

    // Scrambling choice applied to the coded result
    typedef enum logic [1:0] {
        SCR_NONE = 2'd0,
        SCR_LSB  = 2'd1,
        SCR_PRBS = 2'd2
    } scr_mode_e;

    localparam int unsigned DEF_SMP_W   = 18;
    localparam int unsigned DEF_TAG_W   = 6;
    localparam int unsigned DEF_DEPTH_W = 2;

endpackage

// File: rtl/cond_avg.sv
module cond_avg #(
    parameter int unsigned SMP_W   = 18,
    parameter int unsigned DEPTH_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             en_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic             res_vld_o,
    output logic [SMP_W-1:0] res_o
);
    localparam int unsigned CNT_W = 2 ** DEPTH_W;
    localparam int unsigned ACC_W = SMP_W + CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } avg_st_t;

    avg_st_t st_d, st_q;

    logic [CNT_W:0]          last_idx;
    logic [DEPTH_W:0]        shamt;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        st_d      = st_q;
        res_vld_o = 1'b0;
        res_o     = smp_i;
        shamt     = {1'b0, depth_i} + 1'b1;
        last_idx  = ((CNT_W+1)'(1) << shamt) - 1'b1;
        sum       = (st_q.cnt == '0) ? ACC_W'($signed(smp_i))
                                     : $signed(st_q.acc) + ACC_W'($signed(smp_i));
        shifted   = sum >>> shamt;
        if (!en_i) begin
            st_d      = '0;
            res_vld_o = vld_i;
        end else if (vld_i) begin
            if ({1'b0, st_q.cnt} == last_idx) begin
                res_vld_o = 1'b1;
                res_o     = shifted[SMP_W-1:0];
                st_d.cnt  = '0;
                st_d.acc  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cond_prbs.sv
module cond_prbs #(
    parameter int unsigned        LEN  = 23,
    parameter int unsigned        TAP  = 18,
    parameter logic [LEN-1:0]     SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic bit_o
);
    logic [LEN-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step_i) lfsr_d = {lfsr_q[LEN-2:0], lfsr_q[LEN-1] ^ lfsr_q[TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign bit_o = lfsr_q[LEN-1];

endmodule

// File: rtl/cond_fmt.sv
module cond_fmt
    import adc_cond_pkg::*;
#(
    parameter int unsigned SMP_W = 18,
    parameter int unsigned TAG_W = 6,
    localparam int unsigned OUT_W = SMP_W + TAG_W
) (
    input  logic [SMP_W-1:0] res_i,
    input  logic             twos_i,
    input  scr_mode_e        mode_i,
    input  logic             prbs_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [OUT_W-1:0] word_o
);
    logic [SMP_W-1:0] coded;

    always_comb begin
        coded = res_i;
        if (!twos_i) coded[SMP_W-1] = ~res_i[SMP_W-1];
        case (mode_i)
            SCR_LSB:  word_o = {coded[SMP_W-1:1] ^ {(SMP_W-1){coded[0]}}, coded[0], tag_i};
            SCR_PRBS: word_o = {coded ^ {SMP_W{prbs_i}}, prbs_i, tag_i[TAG_W-2:0]};
            default:  word_o = {coded, tag_i};
        endcase
    end

endmodule

// File: rtl/adc_cond_pipe.sv
module adc_cond_pipe
    import adc_cond_pkg::*;
#(
    parameter int unsigned SMP_W   = DEF_SMP_W,
    parameter int unsigned TAG_W   = DEF_TAG_W,
    parameter int unsigned DEPTH_W = DEF_DEPTH_W,
    localparam int unsigned OUT_W  = SMP_W + TAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld_i,
    input  logic [SMP_W-1:0]   smp_i,
    input  logic               avg_en_i,
    input  logic [DEPTH_W-1:0] avg_depth_i,
    input  logic               fmt_twos_i,
    input  logic               xor_en_i,
    input  logic               xor_prbs_i,
    input  logic [TAG_W-1:0]   tag_i,
    output logic               out_vld_o,
    output logic [OUT_W-1:0]   out_word_o
);
    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] word;
    } out_st_t;

    out_st_t   out_d, out_q;
    logic      avg_vld;
    logic [SMP_W-1:0] avg_res;
    logic      prbs_bit;
    scr_mode_e mode;
    logic [OUT_W-1:0] word_c;

    cond_avg #(.SMP_W(SMP_W), .DEPTH_W(DEPTH_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .vld_i(smp_vld_i), .smp_i(smp_i),
        .en_i(avg_en_i), .depth_i(avg_depth_i),
        .res_vld_o(avg_vld), .res_o(avg_res)
    );

    cond_prbs #(.LEN(23), .TAP(18), .SEED('1)) u_prbs (
        .clk(clk), .rst_n(rst_n), .step_i(avg_vld), .bit_o(prbs_bit)
    );

    always_comb begin
        mode = SCR_NONE;
        if (xor_en_i) mode = xor_prbs_i ? SCR_PRBS : SCR_LSB;
    end

    cond_fmt #(.SMP_W(SMP_W), .TAG_W(TAG_W)) u_fmt (
        .res_i(avg_res), .twos_i(fmt_twos_i), .mode_i(mode),
        .prbs_i(prbs_bit), .tag_i(tag_i), .word_o(word_c)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = avg_vld;
        if (avg_vld) out_d.word = word_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_vld_o  = out_q.vld;
    assign out_word_o = out_q.word;

endmodule

// File: rtl/adc_cond_pipe_chk.sv
module adc_cond_pipe_chk #(
    parameter int unsigned SMP_W   = 18,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DEPTH_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_vld_i,
    input logic [SMP_W-1:0]   smp_i,
    input logic               avg_en_i,
    input logic [DEPTH_W-1:0] avg_depth_i,
    input logic               fmt_twos_i,
    input logic               xor_en_i,
    input logic               xor_prbs_i,
    input logic [TAG_W-1:0]   tag_i,
    input logic               out_vld_o,
    input logic [SMP_W+TAG_W-1:0] out_word_o
);
    p_pass_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !avg_en_i) |=> out_vld_o);

    p_avg_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_en_i && out_vld_o) |=> !out_vld_o);

    p_lsb_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !avg_en_i && fmt_twos_i && xor_en_i && !xor_prbs_i)
        |=> out_word_o[TAG_W] == $past(smp_i[0]));

    p_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && !$past(xor_en_i && xor_prbs_i))
        |-> out_word_o[TAG_W-1:0] == $past(tag_i));

    p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(smp_vld_i));

endmodule

bind adc_cond_pipe adc_cond_pipe_chk #(.SMP_W(SMP_W), .TAG_W(TAG_W), .DEPTH_W(DEPTH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .avg_en_i(avg_en_i), .avg_depth_i(avg_depth_i), .fmt_twos_i(fmt_twos_i),
    .xor_en_i(xor_en_i), .xor_prbs_i(xor_prbs_i), .tag_i(tag_i),
    .out_vld_o(out_vld_o), .out_word_o(out_word_o)
);

// File: tb/adc_cond_pipe_test.sv
`timescale 1ns/1ps
module adc_cond_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [17:0] smp = '0;
    logic        avg_en = 1'b0;
    logic [1:0]  depth = '0;
    logic        fmt = 1'b1;
    logic        xen = 1'b0;
    logic        xprbs = 1'b0;
    logic [5:0]  tag = '0;
    logic        out_vld;
    logic [23:0] out_word;

    int total = 0;
    int bad = 0;
    logic [22:0] model_lfsr;

    always #2.5 clk = ~clk;

    adc_cond_pipe uut (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_i(smp),
        .avg_en_i(avg_en), .avg_depth_i(depth), .fmt_twos_i(fmt),
        .xor_en_i(xen), .xor_prbs_i(xprbs), .tag_i(tag),
        .out_vld_o(out_vld), .out_word_o(out_word)
    );

    // {fmt, xor_en, xor_src, tag[5:0], sample[17:0], expected word[23:0]}
    localparam logic [50:0] VEC [7] = '{
        {1'b1, 1'b0, 1'b0, 6'h15, 18'h00005, 24'h000155},
        {1'b0, 1'b0, 1'b0, 6'h2A, 18'h00005, 24'h80016A},
        {1'b1, 1'b0, 1'b0, 6'h3F, 18'h3FFFF, 24'hFFFFFF},
        {1'b0, 1'b0, 1'b0, 6'h00, 18'h20000, 24'h000000},
        {1'b1, 1'b1, 1'b0, 6'h01, 18'h00003, 24'hFFFF41},
        {1'b1, 1'b1, 1'b0, 6'h00, 18'h0000A, 24'h000280},
        {1'b0, 1'b1, 1'b0, 6'h05, 18'h00001, 24'h7FFFC5}
    };

    task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [17:0] s);
        @(negedge clk);
        smp = s;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R10 idle", {23'd0, out_vld}, 24'd0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R9 strobe", {23'd0, out_vld}, 24'd0);
        chk(out_word == 24'd0, "R9 word", out_word, 24'd0);
        rst_n = 1'b1;
        model_lfsr = '1;
    endtask

    // runs one averaging block, checking the strobe after every sample
    task automatic avg_block(input int n, input int vals[16], input string req);
        int sum;
        logic signed [31:0] e;
        sum = 0;
        for (int i = 0; i < n; i++) begin
            send(vals[i][17:0]);
            sum += vals[i];
            chk(out_vld == (i == n - 1), "R2 strobe", {23'd0, out_vld}, {23'd0, i == n - 1});
        end
        e = sum >>> $clog2(n);
        chk(out_word == {e[17:0], tag}, req, out_word, {e[17:0], tag});
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int vals[16];
        logic p;
        logic [23:0] e;
        do_reset();

        // table: pass-through coding and LSB scrambling (R1 R4 R5 R8)
        for (int k = 0; k < 7; k++) begin
            fmt = VEC[k][50];
            xen = VEC[k][49];
            xprbs = VEC[k][48];
            tag = VEC[k][47:42];
            send(VEC[k][41:24]);
            chk(out_vld == 1'b1, "R1 strobe", {23'd0, out_vld}, 24'd1);
            chk(out_word == VEC[k][23:0], "R1/R4/R5/R8 word", out_word, VEC[k][23:0]);
        end
        idle(2);

        fmt = 1'b1; xen = 1'b0; tag = 6'h2C; avg_en = 1'b1;

        // depth 2 with idle gaps: R3 floor of 7/2 = 3, R10 keeps partial sum
        depth = 2'd0;
        send(18'd3);
        chk(out_vld == 1'b0, "R2 first of two", {23'd0, out_vld}, 24'd0);
        idle(3);
        send(18'd4);
        chk(out_vld == 1'b1, "R2 second of two", {23'd0, out_vld}, 24'd1);
        chk(out_word == {18'd3, 6'h2C}, "R3 avg2", out_word, {18'd3, 6'h2C});

        // depth 4, negative sum -7 -> floor -2 (R3)
        depth = 2'd1;
        vals = '{-1, -2, -2, -2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        avg_block(4, vals, "R3 avg4 negative");

        // depth 16, mixed signs, sum 1000+... not a multiple of 16
        depth = 2'd3;
        vals = '{1000, -300, 77, 5, -131071, 131071, 12, 9, -8, 3, 250, -1, 44, 60, -2, 1};
        avg_block(16, vals, "R3 avg16");

        // R11: partial block dropped when averaging pauses
        depth = 2'd1;
        send(18'd100); send(18'd100); send(18'd100);
        @(negedge clk); avg_en = 1'b0;
        @(negedge clk); avg_en = 1'b1;
        chk(out_vld == 1'b0, "R11 pause", {23'd0, out_vld}, 24'd0);
        vals = '{8, 8, 8, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        avg_block(4, vals, "R11 fresh block");

        // random scrambling after fresh reset (R6 R7)
        avg_en = 1'b0;
        do_reset();
        xen = 1'b1; xprbs = 1'b1; fmt = 1'b1; tag = 6'h2B;
        for (int k = 0; k < 30; k++) begin
            logic [17:0] s;
            s = 18'(k * 4099 + 17);
            send(s);
            p = model_lfsr[22];
            e = {s ^ {18{p}}, p, tag[4:0]};
            if (k == 0) chk(out_word[5] == 1'b1, "R7 seed", {23'd0, out_word[5]}, 24'd1);
            chk(out_vld == 1'b1 && out_word == e, "R6/R7 word", out_word, e);
            model_lfsr = {model_lfsr[21:0], model_lfsr[22] ^ model_lfsr[17]};
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule